// File: doc/BRIEF.md
# Row-Register Cached Dynamic Memory

This block models a dynamic memory whose reads are all served from one on-chip row register. The row register holds a complete array row and works as a one-line cache. A tag latch keeps the row number of the most recent read fill. Each incoming row address is compared against this tag. A match is a hit, and the read completes in one cycle from the row register alone. A mismatch is a miss. On a miss the memory fetches the whole addressed row from the array in one wide transfer, loads it into the row register, updates the tag and returns the data three cycles after acceptance.

Writes are posted into a holding latch and committed to the array on the following cycle, whether they hit or miss. When a write hits, the row register is updated on the same edge, so a later hit returns the new value. A write that misses leaves both the row register and the tag untouched.

A refresh counter with its own path refreshes array rows in the background. Refresh work is deferred while the array port is busy with a fill or a write commit, but a pending request is never lost. Read hits never touch the array, so refresh can run alongside them. The default geometry is 16 rows by 8 columns of 4-bit entries, kept small for elaboration. Every width is a parameter.

Top module: `rowreg_dram`

## Requirements
- R1: After reset, ready is 1, rd_valid and rfsh_ack are 0, array and row register read as zero, and the tag is invalid, so the first read of any row is a miss.
- R2: A read whose row equals the valid tag raises rd_valid with the addressed entry exactly one cycle after acceptance, and ready stays 1.
- R3: A read miss holds ready at 0 for the two cycles after acceptance and raises rd_valid with the array data three cycles after acceptance. The read row then becomes the tag.
- R4: Every accepted write is committed to the array on the next clock edge, whether it hits or misses. A later miss read of that location returns the written value.
- R5: A write whose row equals the valid tag also updates the row register entry on its acceptance edge, so the next read hit returns the new value.
- R6: A write that misses changes neither the row register nor the tag. A following hit to the tagged row still returns the old data.
- R7: With no refresh pending, back-to-back writes are accepted every cycle (ready stays 1).
- R8: Each rfsh_req cycle adds one pending refresh. A pending refresh executes on the first edge at which the array port is idle. One cycle later rfsh_ack pulses, and rfsh_row shows the refreshed row. Refreshed rows step 0, 1, 2, … and wrap modulo the row count.
- R9: A write commit or a miss row fetch takes the array port ahead of refresh. While a refresh is pending and a commit is in progress, ready drops to 0, so a refresh waits at most one edge after it becomes pending.
- R10: Read hits keep their one-cycle latency while a refresh executes, and refresh leaves array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (4) | Row address |
| req_col | input | COL_W (3) | Column address |
| req_wdata | input | DQ_W (4) | Write data |
| rfsh_req | input | 1 | Refresh request, one per cycle high |
| ready | output | 1 | Command accepted at this edge when high with req_valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DQ_W (4) | Read data, from the row register or the filling row |
| rfsh_ack | output | 1 | Pulse: a refresh was executed |
| rfsh_row | output | ROW_W (4) | Row number of the latest refresh |

## Verification
The hardest condition to reach is a refresh that collides with array traffic. This is a pending refresh in the same edge as a posted write commit or a miss row fetch. It must be pushed back exactly one edge, and it must not be dropped or allowed to starve. The bench creates these collisions by raising rfsh_req in the same cycle it issues a write or a missing read. It then samples ready, rfsh_ack and rd_valid on each of the following cycles. It also fires refreshes alongside read hits, and afterwards re-reads rows that were written before the refreshes, to show that hit latency and stored data are unaffected.

// File: rtl/rowcache_pkg.sv
package rowcache_pkg;

    // Controller phases for the array side of a read miss.
    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_FETCH = 2'd1,
        CTL_FILL  = 2'd2
    } ctl_state_e;

    // Bit offset of one column entry inside a packed row line.
    function automatic int unsigned slot_lsb(input int unsigned col, input int unsigned dq_w);
        return col * dq_w;
    endfunction

endpackage

// File: rtl/rowcache_array.sv
module rowcache_array #(
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    parameter int DQ_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ROW_W-1:0]                wr_row,
    input  logic [COL_W-1:0]                wr_col,
    input  logic [DQ_W-1:0]                 wr_data,
    input  logic                            rd_en,
    input  logic [ROW_W-1:0]                rd_row,
    output logic [(1<<COL_W)*DQ_W-1:0]      rd_line
);
    import rowcache_pkg::*;

    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int LINE_W = COLS * DQ_W;

    logic [LINE_W-1:0] cells [ROWS];

    // Single array port: write commit or full-row fetch (never both, by controller).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= '0;
            end
            rd_line <= '0;
        end else begin
            if (wr_en) begin
                cells[wr_row][slot_lsb(int'(wr_col), DQ_W) +: DQ_W] <= wr_data;
            end
            if (rd_en) begin
                rd_line <= cells[rd_row];
            end
        end
    end

endmodule

// File: rtl/rowcache_tag.sv
module rowcache_tag #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] cmp_row,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    output logic             hit,
    output logic             tag_valid,
    output logic [ROW_W-1:0] tag_row
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_valid <= 1'b0;
            tag_row   <= '0;
        end else if (load) begin
            tag_valid <= 1'b1;
            tag_row   <= load_row;
        end
    end

    assign hit = tag_valid && (cmp_row == tag_row);

endmodule

// File: rtl/rowcache_refresh.sv
module rowcache_refresh #(
    parameter int ROW_W  = 4,
    parameter int PEND_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             busy,
    output logic             pending,
    output logic             fire,
    output logic             ack,
    output logic [ROW_W-1:0] ack_row
);

    logic [PEND_W-1:0] pend_cnt;
    logic [ROW_W-1:0]  next_row;

    assign pending = (pend_cnt != '0);
    assign fire    = pending && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt <= '0;
            next_row <= '0;
            ack      <= 1'b0;
            ack_row  <= '0;
        end else begin
            pend_cnt <= pend_cnt + PEND_W'(req) - PEND_W'(fire);
            ack      <= fire;
            if (fire) begin
                ack_row  <= next_row;
                next_row <= next_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rowreg_dram.sv
module rowreg_dram #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DQ_W   = 4,
    parameter int PEND_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic             rfsh_req,
    output logic             ready,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data,
    output logic             rfsh_ack,
    output logic [ROW_W-1:0] rfsh_row
);
    import rowcache_pkg::*;

    localparam int COLS   = 1 << COL_W;
    localparam int LINE_W = COLS * DQ_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  data;
    } wpost_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } rdaddr_t;

    ctl_state_e        state;
    wpost_t            post_q;
    logic              post_v;
    rdaddr_t           miss_q;
    logic [LINE_W-1:0] rowreg;
    logic [LINE_W-1:0] arr_line;

    logic             tag_hit;
    logic             tag_valid;
    logic [ROW_W-1:0] tag_row;
    logic             acc, rd_hit, rd_miss, wr_hit, wr_miss;
    logic             arr_busy, arr_rd_en, fill_now;
    logic             rfsh_pend, rfsh_fire;

    assign fill_now  = (state == CTL_FILL);
    assign arr_rd_en = (state == CTL_FETCH);
    assign arr_busy  = post_v || arr_rd_en;

    // Hold off new commands while a refresh waits behind a commit.
    assign ready = (state == CTL_IDLE) && !(rfsh_pend && post_v);

    assign acc     = req_valid && ready;
    assign rd_hit  = acc && !req_write && tag_hit;
    assign rd_miss = acc && !req_write && !tag_hit;
    assign wr_hit  = acc && req_write && tag_hit;
    assign wr_miss = acc && req_write && !tag_hit;

    rowcache_tag #(.ROW_W(ROW_W)) i_tag (
        .clk       (clk),
        .rst       (rst),
        .cmp_row   (req_row),
        .load      (fill_now),
        .load_row  (miss_q.row),
        .hit       (tag_hit),
        .tag_valid (tag_valid),
        .tag_row   (tag_row)
    );

    rowcache_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) i_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (post_v),
        .wr_row  (post_q.row),
        .wr_col  (post_q.col),
        .wr_data (post_q.data),
        .rd_en   (arr_rd_en),
        .rd_row  (miss_q.row),
        .rd_line (arr_line)
    );

    rowcache_refresh #(.ROW_W(ROW_W), .PEND_W(PEND_W)) i_refresh (
        .clk     (clk),
        .rst     (rst),
        .req     (rfsh_req),
        .busy    (arr_busy),
        .pending (rfsh_pend),
        .fire    (rfsh_fire),
        .ack     (rfsh_ack),
        .ack_row (rfsh_row)
    );

    // Miss sequencing: fetch row, then fill the row register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CTL_IDLE;
            miss_q <= '0;
        end else begin
            unique case (state)
                CTL_IDLE: begin
                    if (rd_miss) begin
                        state      <= CTL_FETCH;
                        miss_q.row <= req_row;
                        miss_q.col <= req_col;
                    end
                end
                CTL_FETCH: state <= CTL_FILL;
                CTL_FILL:  state <= CTL_IDLE;
                default:   state <= CTL_IDLE;
            endcase
        end
    end

    // Posted write latch, committed to the array one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            post_v <= 1'b0;
            post_q <= '0;
        end else begin
            post_v <= acc && req_write;
            if (acc && req_write) begin
                post_q.row  <= req_row;
                post_q.col  <= req_col;
                post_q.data <= req_wdata;
            end
        end
    end

    // Row register: whole-line fill on a miss, single entry on a write hit.
    always_ff @(posedge clk) begin
        if (rst) begin
            rowreg <= '0;
        end else if (fill_now) begin
            rowreg <= arr_line;
        end else if (wr_hit) begin
            rowreg[slot_lsb(int'(req_col), DQ_W) +: DQ_W] <= req_wdata;
        end
    end

    // Read return path.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_hit || fill_now;
            if (rd_hit) begin
                rd_data <= rowreg[slot_lsb(int'(req_col), DQ_W) +: DQ_W];
            end else if (fill_now) begin
                rd_data <= arr_line[slot_lsb(int'(miss_q.col), DQ_W) +: DQ_W];
            end
        end
    end

endmodule

// File: rtl/rowreg_dram_chk.sv
module rowreg_dram_chk #(
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic             rd_valid,
    input logic             req_write,
    input logic [ROW_W-1:0] req_row,
    input logic             acc,
    input logic             rd_hit,
    input logic             rd_miss,
    input logic             wr_miss,
    input logic             post_v,
    input logic [ROW_W-1:0] post_row,
    input logic             tag_valid,
    input logic [ROW_W-1:0] tag_row,
    input logic             arr_busy,
    input logic             rfsh_pend,
    input logic             rfsh_fire,
    input logic             rfsh_ack
);

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> rd_valid); // R2

    AST_MISS_THREE_CYCLES: assert property (@(posedge clk) disable iff (rst)
        rd_miss |=> !ready ##1 !ready ##1 rd_valid); // R3

    AST_MISS_LOADS_TAG: assert property (@(posedge clk) disable iff (rst)
        rd_miss |=> ##2 (tag_valid && tag_row == $past(req_row, 3))); // R3

    AST_WRITE_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write) |=> (post_v && post_row == $past(req_row))); // R4

    AST_WMISS_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
        wr_miss |=> ($stable(tag_valid) && $stable(tag_row))); // R6

    AST_REFRESH_PORT_FREE: assert property (@(posedge clk) disable iff (rst)
        rfsh_fire |-> !arr_busy); // R9

    AST_REFRESH_WAIT_ONE: assert property (@(posedge clk) disable iff (rst)
        (rfsh_pend && arr_busy) |=> !arr_busy); // R9

    AST_REFRESH_ACK: assert property (@(posedge clk) disable iff (rst)
        rfsh_fire |=> rfsh_ack); // R8

endmodule

bind rowreg_dram rowreg_dram_chk #(.ROW_W(ROW_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .req_write (req_write),
    .req_row   (req_row),
    .acc       (acc),
    .rd_hit    (rd_hit),
    .rd_miss   (rd_miss),
    .wr_miss   (wr_miss),
    .post_v    (post_v),
    .post_row  (post_q.row),
    .tag_valid (tag_valid),
    .tag_row   (tag_row),
    .arr_busy  (arr_busy),
    .rfsh_pend (rfsh_pend),
    .rfsh_fire (rfsh_fire),
    .rfsh_ack  (rfsh_ack)
);

// File: tb/test_rowreg_dram.sv
module test_rowreg_dram;

    localparam int ROW_W = 4;
    localparam int COL_W = 3;
    localparam int DQ_W  = 4;
    localparam int ROWS  = 1 << ROW_W;
    localparam int NVEC  = 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DQ_W-1:0]  req_wdata = '0;
    logic             rfsh_req = 1'b0;
    logic             ready, rd_valid, rfsh_ack;
    logic [DQ_W-1:0]  rd_data;
    logic [ROW_W-1:0] rfsh_row;

    int checks = 0;
    int failures = 0;
    int rf_count = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rowreg_dram #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) i_rowreg_dram (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rfsh_req(rfsh_req), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rfsh_ack(rfsh_ack), .rfsh_row(rfsh_row)
    );

    // {write, row, col, wdata, expected latency, expected read data}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 4'd2,  3'd1, 4'hA, 2'd0, 4'h0},  // write miss (tag invalid) R4
        {1'b1, 4'd2,  3'd5, 4'h5, 2'd0, 4'h0},  // write miss R4
        {1'b0, 4'd2,  3'd1, 4'h0, 2'd3, 4'hA},  // first read: miss R1 R3
        {1'b0, 4'd2,  3'd5, 4'h0, 2'd1, 4'h5},  // hit R2
        {1'b0, 4'd2,  3'd0, 4'h0, 2'd1, 4'h0},  // hit R2
        {1'b1, 4'd2,  3'd0, 4'hC, 2'd0, 4'h0},  // write hit R5
        {1'b0, 4'd2,  3'd0, 4'h0, 2'd1, 4'hC},  // hit sees new value R5
        {1'b1, 4'd7,  3'd3, 4'h9, 2'd0, 4'h0},  // write miss R6
        {1'b0, 4'd2,  3'd3, 4'h0, 2'd1, 4'h0},  // tag unchanged R6
        {1'b0, 4'd7,  3'd3, 4'h0, 2'd3, 4'h9},  // miss sees commit R4
        {1'b0, 4'd2,  3'd0, 4'h0, 2'd3, 4'hC},  // miss, array has hit write R4
        {1'b0, 4'd15, 3'd7, 4'h0, 2'd3, 4'h0},  // miss R3
        {1'b1, 4'd15, 3'd7, 4'hF, 2'd0, 4'h0},  // write hit R5
        {1'b0, 4'd15, 3'd7, 4'h0, 2'd1, 4'hF}   // hit R5
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input bit wr, input int row, input int col, input int data,
                       output int lat, output int q);
        req_valid = 1'b1;
        req_write = wr;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_wdata = DQ_W'(data);
        while (!ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        q = 0;
        if (!wr) begin
            while (!rd_valid && lat < 8) begin
                @(negedge clk);
                lat++;
            end
            q = int'(rd_data);
        end
    endtask

    task automatic refresh_one(input string req);
        int wait_n = 0;
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
        while (!rfsh_ack && wait_n < 6) begin
            @(negedge clk);
            wait_n++;
        end
        check(rfsh_ack == 1'b1, req, int'(rfsh_ack), 1);
        check(int'(rfsh_row) == rf_count % ROWS, req, int'(rfsh_row), rf_count % ROWS);
        rf_count++;
    endtask

    initial begin
        int lat, q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(ready == 1'b1, "R1 ready", int'(ready), 1);
        check(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
        check(rfsh_ack == 1'b0, "R1 rfsh_ack", int'(rfsh_ack), 0);

        for (int i = 0; i < NVEC; i++) begin
            cmd(VEC[i][17], int'(VEC[i][16:13]), int'(VEC[i][12:10]), int'(VEC[i][9:6]), lat, q);
            if (!VEC[i][17]) begin
                check(lat == int'(VEC[i][5:4]), $sformatf("R2/R3 latency vec %0d", i), lat, int'(VEC[i][5:4]));
                check(q == int'(VEC[i][3:0]), $sformatf("R2/R3/R4/R5/R6 data vec %0d", i), q, int'(VEC[i][3:0]));
            end
        end

        // R8: refresh on an idle array, acknowledged two edges after the request
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
        check(rfsh_ack == 1'b0, "R8 ack early", int'(rfsh_ack), 0);
        @(negedge clk);
        check(rfsh_ack == 1'b1, "R8 ack", int'(rfsh_ack), 1);
        check(rfsh_row == 4'd0, "R8 row", int'(rfsh_row), 0);
        rf_count = 1;

        // R9: refresh colliding with a write commit
        req_valid = 1'b1; req_write = 1'b1; req_row = 4'd3; req_col = 3'd2; req_wdata = 4'h6;
        rfsh_req = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rfsh_req = 1'b0;
        check(ready == 1'b0, "R9 ready held low", int'(ready), 0);
        check(rfsh_ack == 1'b0, "R9 ack deferred", int'(rfsh_ack), 0);
        @(negedge clk);
        check(rfsh_ack == 1'b0, "R9 ack deferred 2", int'(rfsh_ack), 0);
        check(ready == 1'b1, "R9 ready back", int'(ready), 1);
        @(negedge clk);
        check(rfsh_ack == 1'b1, "R9 ack", int'(rfsh_ack), 1);
        check(rfsh_row == 4'd1, "R9 row", int'(rfsh_row), 1);
        rf_count = 2;

        // R9: refresh colliding with a miss row fetch
        req_valid = 1'b1; req_write = 1'b0; req_row = 4'd3; req_col = 3'd2;
        rfsh_req = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rfsh_req = 1'b0;
        check(rfsh_ack == 1'b0, "R9 miss ack early", int'(rfsh_ack), 0);
        @(negedge clk);
        check(rfsh_ack == 1'b0, "R9 miss ack deferred", int'(rfsh_ack), 0);
        check(rd_valid == 1'b0, "R3 miss not yet valid", int'(rd_valid), 0);
        @(negedge clk);
        check(rfsh_ack == 1'b1, "R9 miss ack", int'(rfsh_ack), 1);
        check(rfsh_row == 4'd2, "R9 miss row", int'(rfsh_row), 2);
        check(rd_valid == 1'b1, "R3 miss valid", int'(rd_valid), 1);
        check(rd_data == 4'h6, "R4 miss data", int'(rd_data), 6);
        rf_count = 3;

        // R10: refresh runs alongside read hits
        req_valid = 1'b1; req_write = 1'b0; req_row = 4'd3; req_col = 3'd2;
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
        check(rd_valid == 1'b1, "R10 hit latency", int'(rd_valid), 1);
        check(rd_data == 4'h6, "R10 hit data", int'(rd_data), 6);
        check(ready == 1'b1, "R10 ready", int'(ready), 1);
        req_col = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rfsh_ack == 1'b1, "R10 refresh with hit", int'(rfsh_ack), 1);
        check(rfsh_row == 4'd3, "R10 refresh row", int'(rfsh_row), 3);
        check(rd_valid == 1'b1, "R10 hit during refresh", int'(rd_valid), 1);
        check(rd_data == 4'h0, "R10 hit data 2", int'(rd_data), 0);
        rf_count = 4;

        // R7: back-to-back writes, then R5 hit read-back
        req_valid = 1'b1; req_write = 1'b1; req_row = 4'd3;
        for (int k = 0; k < 3; k++) begin
            req_col = COL_W'(4 + k);
            req_wdata = DQ_W'(1 + k);
            check(ready == 1'b1, "R7 ready every cycle", int'(ready), 1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        cmd(1'b0, 3, 5, 0, lat, q);
        check(lat == 1, "R5 hit latency", lat, 1);
        check(q == 2, "R5 burst write hit data", q, 2);

        // R8: walk the refresh counter through its wrap
        for (int k = 0; k < 13; k++) begin
            refresh_one("R8 refresh sequence");
        end
        check(rfsh_row == 4'd0, "R8 wrap", int'(rfsh_row), 0);

        // R10: data survives refreshes
        cmd(1'b0, 7, 3, 0, lat, q);
        check(lat == 3, "R10 miss latency", lat, 3);
        check(q == 9, "R10 data kept", q, 9);

        // R1: reset mid-run, first read is again a miss
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cmd(1'b0, 3, 2, 0, lat, q);
        check(lat == 3, "R1 first read misses", lat, 3);
        check(q == 0, "R1 array cleared", q, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog (R1-R10 run) actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule